// File: doc/BRIEF.md
# Gated watchdog reset controller

This block produces the active-low system reset `lrst_n` from three sources. The first is a digital flag from a supply monitor. The second is a watchdog timeout. The third is a test input that decides whether the watchdog is allowed to cause a reset at all. A processor reaches the block through a small synchronous bus with active-low chip-enable, write and read strobes. Writing any value to the kick address restarts the watchdog. A read drives an 8-bit input port onto a bidirectional data bus. A 3-bit register holds the LCD bias step code (eight steps, 0 to 1.4 V in 0.2 V increments). The conversion to a voltage is done elsewhere.

The watchdog advances only while `lrst_n` is high. If no kick arrives within `TIMEOUT_CYCLES` clocks and `test_mode` is low, `lrst_n` is pulled low for `PULSE_CYCLES` clocks. The watchdog then starts over from zero. While `lrst_n` is low, every control register is returned to its initial value. The supply flag and the test input are brought into the clock domain through two flip-flops each. There is no data stream, so there is no valid/ready handshake. Strobes are sampled on each rising clock edge.

Top module: `wdt_rst_ctrl`

## Requirements
- R1: While `arst_n` is low, `lrst_n` is 0 and `lcd_level` is 0. After `arst_n` rises, `lrst_n` stays low for `PULSE_CYCLES` clocks and then goes high.
- R2: A write with `ce_n`=0, `wr_n`=0 and `addr`=0 (any data) clears the watchdog. Kicks spaced closer than `TIMEOUT_CYCLES` keep `lrst_n` high.
- R3: With no kick and `test_mode` low, `lrst_n` falls about `TIMEOUT_CYCLES`+1 clocks (within one clock either way) after the last kick. It then stays low for exactly `PULSE_CYCLES` clocks.
- R4: While `test_mode` is high, the watchdog never pulls `lrst_n` low.
- R5: While `supply_low` is 1, `lrst_n` is 0, after a two-clock synchroniser delay. Holding `supply_low` high for N clocks gives a low pulse of N clocks.
- R6: A write with `ce_n`=0, `wr_n`=0 and `addr`=1 loads `db[2:0]` into `lcd_level`. Bits 7:3 are discarded.
- R7: Whenever `lrst_n` is low, `lcd_level` returns to code 0.
- R8: While `ce_n` is 1, `wr_n` and `rd_n` have no effect: `lcd_level` keeps its value and `db` is released.
- R9: With `ce_n`=0 and `rd_n`=0, `db` carries `pin`. Otherwise `db` is high impedance.
- R10: The watchdog is held cleared while `lrst_n` is low. The next timeout is measured from the release of the reset, so a missing kick gives one pulse per period and never a pulse that runs straight on into another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Power-on reset, asynchronous, active low |
| supply_low | input | 1 | Supply monitor flag, 1 = below threshold |
| test_mode | input | 1 | 1 = watchdog may not reset |
| ce_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 2 | Register select (0 = kick, 1 = level) |
| db | inout | 8 | Bidirectional data bus |
| pin | input | 8 | General input port, returned on reads |
| lcd_level | output | 3 | LCD bias step code |
| lrst_n | output | 1 | System reset, active low |

## Verification
The hardest situation to reach is a second watchdog pulse that follows directly on the first with no kick in between. That second pulse shows whether the counter was frozen during the reset or kept running. The stimulus stops kicking, lets one pulse pass, and measures the high gap from release to the next fall. It then raises `test_mode` during the second pulse to stop a third. A level code written just before the kicks stop is checked to read 0 once the pulse has passed.

// File: rtl/wdt_rst_pkg.sv
package wdt_rst_pkg;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 8;
  localparam int LEVEL_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_KICK  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LEVEL = 2'd1;
  typedef logic [LEVEL_W-1:0] level_t;
endpackage

// File: rtl/wdt_sync2.sv
module wdt_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int TIMEOUT_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic lrst_n,
  input  logic kick,
  output logic timeout
);
  localparam int CW = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          at_last;
  assign at_last = (cnt == LAST);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= lrst_n & ~kick & at_last;
      if (!lrst_n || kick || at_last) cnt <= '0;
      else                            cnt <= cnt + 1'b1;
    end
  end

  AST_TIMEOUT_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
    timeout |=> !timeout); // R3
  AST_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!arst_n)
    !lrst_n |=> !timeout); // R10
endmodule

// File: rtl/wdt_reset_gen.sv
module wdt_reset_gen #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic timeout,
  input  logic test_s,
  input  logic supply_s,
  output logic lrst_n
);
  localparam int HW = $clog2(PULSE_CYCLES + 1);
  localparam logic [HW-1:0] LOAD = HW'(PULSE_CYCLES);

  logic [HW-1:0] hold;
  logic          fire;
  assign fire = timeout & ~test_s;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)            hold <= LOAD;
    else if (fire)          hold <= LOAD;
    else if (hold != '0)    hold <= hold - 1'b1;
  end

  assign lrst_n = ~supply_s & (hold == '0);

  AST_TEST_BLOCKS_WDT: assert property (@(posedge clk) disable iff (!arst_n)
    (test_s && hold == '0) |=> (hold == '0)); // R4
endmodule

// File: rtl/wdt_bus_regs.sv
module wdt_bus_regs
  import wdt_rst_pkg::*;
(
  input  logic              clk,
  input  logic              arst_n,
  input  logic              lrst_n,
  input  logic              ce_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pin,
  output logic              kick,
  output level_t            level,
  output logic [DATA_W-1:0] rdata,
  output logic              drive_en
);
  logic wr_ok;
  assign wr_ok    = lrst_n & ~ce_n & ~wr_n;
  assign kick     = wr_ok & (addr == ADDR_KICK);
  assign drive_en = ~ce_n & ~rd_n;
  assign rdata    = pin;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                           level <= '0;
    else if (!lrst_n)                      level <= '0;
    else if (wr_ok && addr == ADDR_LEVEL)  level <= wdata[LEVEL_W-1:0];
  end

  AST_LEVEL_CLEARED: assert property (@(posedge clk) disable iff (!arst_n)
    !lrst_n |=> (level == '0)); // R7
  AST_CE_GATES_WRITE: assert property (@(posedge clk) disable iff (!arst_n)
    (ce_n && lrst_n) |=> $stable(level)); // R8
  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!arst_n)
    (ce_n || rd_n) |-> !drive_en); // R9
endmodule

// File: rtl/wdt_rst_ctrl.sv
module wdt_rst_ctrl
  import wdt_rst_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 50_000_000,
  parameter int PULSE_CYCLES   = 16
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              supply_low,
  input  logic              test_mode,
  input  logic              ce_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] db,
  input  logic [DATA_W-1:0] pin,
  output logic [LEVEL_W-1:0] lcd_level,
  output logic              lrst_n
);
  logic supply_s, test_s, kick, timeout, drive_en;
  logic [DATA_W-1:0] rdata;
  level_t level;

  wdt_sync2 #(.RST_VAL(1'b0)) u_sync_supply (
    .clk(clk), .arst_n(arst_n), .d(supply_low), .q(supply_s));
  wdt_sync2 #(.RST_VAL(1'b1)) u_sync_test (
    .clk(clk), .arst_n(arst_n), .d(test_mode), .q(test_s));

  wdt_bus_regs u_regs (
    .clk(clk), .arst_n(arst_n), .lrst_n(lrst_n), .ce_n(ce_n), .wr_n(wr_n),
    .rd_n(rd_n), .addr(addr), .wdata(db), .pin(pin), .kick(kick),
    .level(level), .rdata(rdata), .drive_en(drive_en));

  wdt_counter #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_wdt (
    .clk(clk), .arst_n(arst_n), .lrst_n(lrst_n), .kick(kick),
    .timeout(timeout));

  wdt_reset_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_rgen (
    .clk(clk), .arst_n(arst_n), .timeout(timeout), .test_s(test_s),
    .supply_s(supply_s), .lrst_n(lrst_n));

  assign db        = drive_en ? rdata : {DATA_W{1'bz}};
  assign lcd_level = level;

  AST_SUPPLY_FORCES_RESET: assert property (@(posedge clk) disable iff (!arst_n)
    supply_s |-> !lrst_n); // R5
endmodule

// File: tb/wdt_rst_ctrl_bench.sv
module wdt_rst_ctrl_bench;
  localparam int T = 50;
  localparam int P = 8;

  logic clk = 0, arst_n = 0, supply_low = 0, test_mode = 1;
  logic ce_n = 1, wr_n = 1, rd_n = 1;
  logic [1:0] addr = 0;
  logic [7:0] pin = 0, bdrv = 0;
  logic bdrv_en = 0;
  tri   [7:0] db;
  logic [2:0] lcd_level;
  logic lrst_n;

  assign db = bdrv_en ? bdrv : 8'hzz;

  wdt_rst_ctrl #(.TIMEOUT_CYCLES(T), .PULSE_CYCLES(P)) u_wdt_rst_ctrl (
    .clk(clk), .arst_n(arst_n), .supply_low(supply_low), .test_mode(test_mode),
    .ce_n(ce_n), .wr_n(wr_n), .rd_n(rd_n), .addr(addr), .db(db), .pin(pin),
    .lcd_level(lcd_level), .lrst_n(lrst_n));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int exp_q[$];
  int falls = 0;
  bit mon_on = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic ce);
    @(negedge clk);
    ce_n = ce; wr_n = 0; addr = a; bdrv = d; bdrv_en = 1;
    @(negedge clk);
    ce_n = 1; wr_n = 1; bdrv_en = 0;
  endtask

  // monitor: measures every low pulse of lrst_n and pops its expected width
  always @(negedge clk) begin : monitor
    int run;
    bit prev;
    if (mon_on) begin
      if (!lrst_n) run++;
      if (prev && !lrst_n) falls++;
      if (!prev && lrst_n) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected reset pulse", run, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(run == e, "R3/R5 reset pulse width", run, e);
        end
        run = 0;
      end
      prev = lrst_n;
    end else begin
      run = 0;
      prev = 1;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int n;
    cyc(3);
    chk(lrst_n == 0, "R1 lrst_n in reset", lrst_n, 0);
    chk(lcd_level == 0, "R1 level in reset", lcd_level, 0);
    arst_n = 1;
    n = 0;
    while (!lrst_n && n < 100) begin @(negedge clk); n++; end
    chk(n == P, "R1 power-up pulse width", n, P);
    mon_on = 1;

    // R9 read path
    pin = 8'hA5;
    @(negedge clk); ce_n = 0; rd_n = 0; #1;
    chk(db == 8'hA5, "R9 read drives pin", db, 8'hA5);
    ce_n = 1; #1;
    chk(db === 8'hzz, "R8 ce_n high releases bus", db, 0);
    ce_n = 0; rd_n = 1; #1;
    chk(db === 8'hzz, "R9 rd_n high releases bus", db, 0);
    ce_n = 1;

    // R6 level writes
    bus_write(2'd1, 8'h05, 0); cyc(1);
    chk(lcd_level == 5, "R6 level write", lcd_level, 5);
    bus_write(2'd1, 8'hFA, 0); cyc(1);
    chk(lcd_level == 2, "R6 low bits only", lcd_level, 2);
    bus_write(2'd1, 8'h07, 1); cyc(1);
    chk(lcd_level == 2, "R8 write ignored with ce_n high", lcd_level, 2);

    // R4 test_mode high: no watchdog reset
    cyc(4 * T);
    chk(falls == 0, "R4 no reset while test_mode high", falls, 0);

    // R2 periodic kicks
    test_mode = 0;
    bus_write(2'd0, 8'h00, 0);
    for (int i = 0; i < 16; i++) begin
      cyc(T / 2 - 2);
      bus_write(2'd0, 8'h3C, 0);
    end
    chk(falls == 0, "R2 kicks prevent reset", falls, 0);

    // R3 / R10 / R7 missing kick
    bus_write(2'd1, 8'h03, 0);
    exp_q.push_back(P); exp_q.push_back(P);
    bus_write(2'd0, 8'h00, 0);
    n = 0;
    while (lrst_n && n < 4 * T) begin @(negedge clk); n++; end
    chk(n >= T && n <= T + 2, "R3 timeout after last kick", n, T + 1);
    while (!lrst_n) @(negedge clk);
    chk(lcd_level == 0, "R7 level cleared by reset", lcd_level, 0);
    n = 0;
    while (lrst_n && n < 4 * T) begin @(negedge clk); n++; end
    chk(n >= T && n <= T + 2, "R10 timeout measured from release", n, T + 1);
    test_mode = 1;
    while (!lrst_n) @(negedge clk);
    cyc(3 * T);
    chk(falls == 2, "R3 one pulse per period", falls, 2);

    // R5 supply flag
    bus_write(2'd1, 8'h06, 0); cyc(1);
    chk(lcd_level == 6, "R6 level before supply reset", lcd_level, 6);
    exp_q.push_back(30);
    supply_low = 1;
    cyc(30);
    supply_low = 0;
    chk(lrst_n == 0, "R5 supply low holds reset", lrst_n, 0);
    cyc(5);
    chk(lrst_n == 1, "R5 reset released", lrst_n, 1);
    chk(lcd_level == 0, "R7 level cleared by supply reset", lcd_level, 0);
    cyc(5);
    chk(exp_q.size() == 0, "R3/R5 all expected pulses seen", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule